// File: doc/BRIEF.md
# Flash Programming Unlock Controller

This block gates the start of an on-chip flash programming operation behind a two-write key sequence on a control register. Software first writes the arming key with a chosen operation mode, then writes the launch key with the same mode. Only then does the controller commit, wait a fixed launch latency, raise its busy flag and hand the page buffer to the memory array through a request/done handshake. Any other bus write between the two key writes cancels the sequence. So does a mode that differs between them.

A page buffer of `PAGE_BYTES` byte latches, each with its own valid flag, collects the data to be programmed. Bytes may be loaded in any order and at scattered offsets. The page address comes from the upper address bits of the first byte loaded into an empty buffer. Only flagged bytes are offered to the array. The valid flags drop when a program operation completes or when the clear mode is launched.

The key sequencer has four states. `SEQ_IDLE` waits for an arming write. `SEQ_ARMED` holds the captured mode. `SEQ_LAUNCH` counts down the launch latency. `SEQ_BUSY` keeps the request raised until the array reports done. The transitions are:
- arm: `SEQ_IDLE` to `SEQ_ARMED`.
- re-arm: `SEQ_ARMED` to itself.
- abort: `SEQ_ARMED` to `SEQ_IDLE`.
- commit: `SEQ_ARMED` to `SEQ_LAUNCH`.
- start: `SEQ_LAUNCH` to `SEQ_BUSY`.
- clear-done: `SEQ_LAUNCH` to `SEQ_IDLE`, taken in the clear mode.
- finish: `SEQ_BUSY` to `SEQ_IDLE`.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the sequencer, the busy flag, the stored mode and every valid flag. After reset, `reg_rdata` reads 0, `prog_req` is low and `prog_valid` is 0.
- R2: A register write whose key field (`reg_wdata[7:4]`) is 5h only arms the sequence. It raises neither busy nor `prog_req`, and it leaves the page buffer unchanged.
- R3: An arming write followed by a launch write (key Ah) starts an operation. The mode field is `reg_wdata[2:1]`, and bits 3 and 0 of a write are ignored. A read of `reg_rdata` gives the busy flag in bit 0 and the last accepted mode in bits 2:1, with all other bits 0.
- R4: The sequence is cancelled by any other write between the two key writes. This covers a page-buffer load, an `other_wr` pulse, or a register write whose key is neither 5h nor Ah. A launch write with no arming write before it does nothing. Idle cycles between the two key writes do not cancel.
- R5: If the launch write carries a mode different from the arming write, the sequence is aborted and nothing starts.
- R6: Busy is still low on the cycle after the launch write. It is high on the cycle after that, for a launch latency of `LAUNCH_LAT` = 2.
- R7: Modes 00 (user array), 01 (extra row) and 10 (configuration bits) raise `prog_req` together with busy. `prog_mode`, `prog_page`, `prog_data` and `prog_valid` are held stable until `prog_done` is seen.
- R8: Mode 11 clears every valid flag at the start point. It issues no request, and busy stays low.
- R9: A load writes `ld_data` at offset `ld_addr[6:0]` and sets that byte's valid flag. Loads may come in any order. `prog_page` is taken from `ld_addr[15:7]` of the first load into an empty buffer; later loads do not change it.
- R10: `prog_done` while busy ends the operation. Busy falls and all valid flags clear at that edge.
- R11: Register writes and loads that arrive during the launch latency or while busy are ignored. The stored mode, the buffer contents, the valid flags and the page address are left unchanged.
- R12: An arming write received while already armed re-arms the sequence with its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data: key in 7:4, mode in 2:1 |
| reg_rdata | output | 8 | Readback: mode in 2:1, busy in 0 |
| other_wr | input | 1 | Any other bus write (cancels an armed sequence) |
| ld_wr | input | 1 | Page-buffer load strobe |
| ld_addr | input | ADDR_W | Load address: offset in the low bits, page in the upper bits |
| ld_data | input | DATA_W | Load data byte |
| busy | output | 1 | Programming in progress |
| prog_req | output | 1 | Request to the memory array |
| prog_mode | output | 2 | Operation mode of the request |
| prog_page | output | ADDR_W-log2(PAGE_BYTES) | Page address of the request |
| prog_data | output | PAGE_BYTES*DATA_W | Page buffer contents, byte i at bits 8i+7:8i |
| prog_valid | output | PAGE_BYTES | Per-byte valid mask |
| prog_done | input | 1 | Completion from the memory array |

## Verification
The bench builds the controller with its defaults: `PAGE_BYTES` = 128, `ADDR_W` = 16, `DATA_W` = 8 and `LAUNCH_LAT` = 2. With these values, loads at offsets 0 and 127 exercise both ends of the buffer. Page addresses spread across the full 9-bit page field. The two-cycle start is observable exactly at the first and second reads after the launch write. A behavioural array stub in the bench holds `prog_done` off for several cycles, which keeps a window open for writes and loads that must be ignored while busy.

// File: rtl/fuc_pkg.sv
package fuc_pkg;

    localparam logic [3:0] KEY_ARM = 4'h5;
    localparam logic [3:0] KEY_GO  = 4'hA;

    typedef enum logic [1:0] {
        MODE_USER  = 2'b00,
        MODE_XROW  = 2'b01,
        MODE_FUSE  = 2'b10,
        MODE_CLEAR = 2'b11
    } fuc_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARMED,
        SEQ_LAUNCH,
        SEQ_BUSY
    } fuc_seq_e;

endpackage

// File: rtl/fuc_key_seq.sv
module fuc_key_seq
    import fuc_pkg::*;
#(
    parameter int LAUNCH_LAT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [3:0] wr_key,
    input  logic [1:0] wr_mode,
    input  logic       ld_wr,
    input  logic       other_wr,
    input  logic       prog_done,
    output logic       busy,
    output logic       prog_req,
    output logic       load_ok,
    output logic       clear_now,
    output logic       finish_now,
    output logic [1:0] mode_q,
    output logic [1:0] op_mode
);

    localparam int CNT_W = $clog2(LAUNCH_LAT) + 1;
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(LAUNCH_LAT - 2);

    fuc_seq_e       state_q, state_d;
    logic [1:0]     arm_q, arm_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic           open_q;

    // Writes are only taken while no operation is committed.
    assign open_q = (state_q == SEQ_IDLE) || (state_q == SEQ_ARMED);

    always_comb begin
        state_d = state_q;
        arm_d   = arm_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (reg_wr && wr_key == KEY_ARM) begin
                    state_d = SEQ_ARMED;
                    arm_d   = wr_mode;
                end
            end
            SEQ_ARMED: begin
                if (ld_wr || other_wr) begin
                    state_d = SEQ_IDLE;
                end else if (reg_wr) begin
                    if (wr_key == KEY_ARM) begin
                        state_d = SEQ_ARMED;
                        arm_d   = wr_mode;
                    end else if (wr_key == KEY_GO && wr_mode == arm_q) begin
                        state_d = SEQ_LAUNCH;
                        cnt_d   = CNT_START;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
            end
            SEQ_LAUNCH: begin
                if (cnt_q == '0) begin
                    state_d = (arm_q == MODE_CLEAR) ? SEQ_IDLE : SEQ_BUSY;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            SEQ_BUSY: begin
                if (prog_done) begin
                    state_d = SEQ_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            arm_q   <= MODE_USER;
            cnt_q   <= '0;
            mode_q  <= MODE_USER;
        end else begin
            state_q <= state_d;
            arm_q   <= arm_d;
            cnt_q   <= cnt_d;
            if (reg_wr && open_q) begin
                mode_q <= wr_mode;
            end
        end
    end

    always_comb begin
        busy       = 1'b0;
        prog_req   = 1'b0;
        clear_now  = 1'b0;
        finish_now = 1'b0;
        load_ok    = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   load_ok = ld_wr;
            SEQ_ARMED:  load_ok = ld_wr;
            SEQ_LAUNCH: clear_now = (cnt_q == '0) && (arm_q == MODE_CLEAR);
            SEQ_BUSY: begin
                busy       = 1'b1;
                prog_req   = 1'b1;
                finish_now = prog_done;
            end
        endcase
    end

    assign op_mode = arm_q;

    AST_NO_EARLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_ARMED && reg_wr && !ld_wr && !other_wr && wr_key == KEY_GO)
        |=> !busy); // R6

    AST_MISMATCH_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_ARMED && reg_wr && wr_key == KEY_GO && wr_mode != arm_q)
        |=> state_q == SEQ_IDLE); // R5

    AST_CLEAR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        clear_now |=> !prog_req && !busy); // R8

    AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr) |=> $stable(mode_q)); // R11

endmodule

// File: rtl/fuc_page_buf.sv
module fuc_page_buf #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ld_en,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [DATA_W-1:0]            ld_data,
    input  logic                         clear,
    output logic [PAGE_BYTES*DATA_W-1:0] data_flat,
    output logic [PAGE_BYTES-1:0]        valid_q,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_q
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]  off;
    logic [PAGE_W-1:0] page_in;

    assign off     = ld_addr[OFF_W-1:0];
    assign page_in = ld_addr[ADDR_W-1:OFF_W];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_latch
        logic [DATA_W-1:0] byte_q;
        logic              hit;
        assign hit = ld_en && (off == OFF_W'(i));
        always_ff @(posedge clk) begin
            if (hit) begin
                byte_q <= ld_data;
            end
        end
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                valid_q[i] <= 1'b0;
            end else if (hit) begin
                valid_q[i] <= 1'b1;
            end
        end
        assign data_flat[i*DATA_W +: DATA_W] = byte_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (ld_en && valid_q == '0) begin
            page_q <= page_in;
        end
    end

    AST_PAGE_FROM_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ld_en && valid_q != '0 && !clear) |=> $stable(page_q)); // R9

endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl
    import fuc_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int LAUNCH_LAT = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    input  logic                         other_wr,
    input  logic                         ld_wr,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [DATA_W-1:0]            ld_data,
    output logic                         busy,
    output logic                         prog_req,
    output logic [1:0]                   prog_mode,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] prog_page,
    output logic [PAGE_BYTES*DATA_W-1:0] prog_data,
    output logic [PAGE_BYTES-1:0]        prog_valid,
    input  logic                         prog_done
);

    logic       load_ok;
    logic       clear_now;
    logic       finish_now;
    logic [1:0] mode_q;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[3], reg_wdata[0]};

    fuc_key_seq #(
        .LAUNCH_LAT (LAUNCH_LAT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .wr_key     (reg_wdata[7:4]),
        .wr_mode    (reg_wdata[2:1]),
        .ld_wr      (ld_wr),
        .other_wr   (other_wr),
        .prog_done  (prog_done),
        .busy       (busy),
        .prog_req   (prog_req),
        .load_ok    (load_ok),
        .clear_now  (clear_now),
        .finish_now (finish_now),
        .mode_q     (mode_q),
        .op_mode    (prog_mode)
    );

    fuc_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (load_ok),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .clear     (clear_now || finish_now),
        .data_flat (prog_data),
        .valid_q   (prog_valid),
        .page_q    (prog_page)
    );

    assign reg_rdata = {5'b0, mode_q, busy};

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (busy && prog_done) |=> (!busy && prog_valid == '0)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (prog_req && !prog_done) |=> (prog_req && $stable(prog_mode) && $stable(prog_page))); // R7

    AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !prog_done) |=> ($stable(prog_valid) && $stable(prog_data))); // R11

endmodule

// File: tb/flash_unlock_ctrl_test.sv
module flash_unlock_ctrl_test;

    localparam int PB = 128;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int PW = AW - 7;
    localparam int DONE_WAIT = 6;

    typedef struct packed {
        logic [1:0]       mode;
        logic [PW-1:0]    page;
        logic [PB-1:0]    mask;
        logic [PB*DW-1:0] data;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             other_wr = 1'b0;
    logic             ld_wr = 1'b0;
    logic [AW-1:0]    ld_addr = '0;
    logic [DW-1:0]    ld_data = '0;
    logic             busy;
    logic             prog_req;
    logic [1:0]       prog_mode;
    logic [PW-1:0]    prog_page;
    logic [PB*DW-1:0] prog_data;
    logic [PB-1:0]    prog_valid;
    logic             prog_done = 1'b0;

    int checks = 0;
    int failures = 0;

    exp_t             q[$];
    logic [PB-1:0]    m_mask = '0;
    logic [PB*DW-1:0] m_data = '0;
    logic [PW-1:0]    m_page = '0;

    always #5 clk = ~clk;

    flash_unlock_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .other_wr(other_wr), .ld_wr(ld_wr),
        .ld_addr(ld_addr), .ld_data(ld_data), .busy(busy),
        .prog_req(prog_req), .prog_mode(prog_mode), .prog_page(prog_page),
        .prog_data(prog_data), .prog_valid(prog_valid), .prog_done(prog_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [PB-1:0] act,
                       input logic [PB-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ld(input logic [PW-1:0] pg, input int off, input logic [7:0] d);
        @(negedge clk);
        ld_wr = 1'b1;
        ld_addr = {pg, 7'(off)};
        ld_data = d;
        if (m_mask == '0) m_page = pg;
        m_mask[off] = 1'b1;
        m_data[off*DW +: DW] = d;
        @(negedge clk);
        ld_wr = 1'b0;
    endtask

    function automatic logic [7:0] kw(input logic [3:0] key, input logic [1:0] mode);
        return {key, 1'b0, mode, 1'b0};
    endfunction

    task automatic settle_idle(input string tag);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, tag, PB'(busy), '0);
        chk(prog_req == 1'b0, tag, PB'(prog_req), '0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Launch key write after the arming write; expectation is queued here.
    task automatic launch_go(input logic [1:0] mode);
        if (mode != 2'b11) begin
            q.push_back('{mode: mode, page: m_page, mask: m_mask, data: m_data});
            m_mask = '0;
        end else begin
            m_mask = '0;
        end
        wr_reg(kw(4'hA, mode));
        chk(busy == 1'b0, "R6 busy one cycle after launch write", PB'(busy), '0);
        @(negedge clk);
        if (mode != 2'b11) begin
            chk(busy == 1'b1, "R6 busy two cycles after launch write", PB'(busy), 1);
            chk(reg_rdata == {5'b0, mode, 1'b1}, "R3 readback while busy",
                PB'(reg_rdata), PB'({5'b0, mode, 1'b1}));
        end else begin
            chk(prog_valid == '0, "R8 clear mode empties valid flags", prog_valid, '0);
            settle_idle("R8 clear mode raises no busy or request");
        end
        wait_idle();
        chk(prog_valid == '0, "R10 valid flags cleared after completion", prog_valid, '0);
    endtask

    task automatic go(input logic [1:0] mode);
        wr_reg(kw(4'h5, mode));
        launch_go(mode);
    endtask

    // Monitor and array stub: compares each request against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && prog_req) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4 R5 R8 unexpected request", 1, 0);
                end else begin
                    exp_t e;
                    bit data_ok;
                    e = q.pop_front();
                    data_ok = 1'b1;
                    for (int i = 0; i < PB; i++) begin
                        if (e.mask[i] && prog_data[i*DW +: DW] != e.data[i*DW +: DW])
                            data_ok = 1'b0;
                    end
                    chk(prog_mode == e.mode, "R7 request mode", PB'(prog_mode), PB'(e.mode));
                    chk(prog_page == e.page, "R9 request page", PB'(prog_page), PB'(e.page));
                    chk(prog_valid == e.mask, "R9 request valid mask", prog_valid, e.mask);
                    chk(data_ok, "R7 request data bytes", PB'(data_ok), 1);
                end
                repeat (DONE_WAIT) @(negedge clk);
                chk(prog_req == 1'b1, "R7 request held until done", PB'(prog_req), 1);
                prog_done = 1'b1;
                @(negedge clk);
                prog_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(reg_rdata == 8'h00, "R1 readback after reset", PB'(reg_rdata), 0);
        chk(prog_req == 1'b0, "R1 no request after reset", PB'(prog_req), 0);
        chk(prog_valid == '0, "R1 valid flags after reset", prog_valid, 0);

        // R9: scattered offsets, page from first load, both buffer ends
        ld(9'h012, 5, 8'hA5);
        ld(9'h012, 100, 8'h64);
        ld(9'h012, 0, 8'h11);
        ld(9'h013, 127, 8'h7F);
        ld(9'h012, 5, 8'h5A);
        // R2: arming write alone does nothing
        wr_reg(kw(4'h5, 2'b00));
        settle_idle("R2 arming write alone");
        chk(reg_rdata == 8'h00, "R2 readback after arming", PB'(reg_rdata), 0);
        launch_go(2'b00);

        // R4: lone launch write
        ld(9'h008, 5, 8'h3C);
        wr_reg(kw(4'hA, 2'b00));
        settle_idle("R4 launch write without arming");
        // R4: load between the keys
        wr_reg(kw(4'h5, 2'b01));
        ld(9'h008, 9, 8'h4D);
        wr_reg(kw(4'hA, 2'b01));
        settle_idle("R4 load between keys");
        // R4: other bus write between the keys
        wr_reg(kw(4'h5, 2'b01));
        @(negedge clk); other_wr = 1'b1;
        @(negedge clk); other_wr = 1'b0;
        wr_reg(kw(4'hA, 2'b01));
        settle_idle("R4 other write between keys");
        // R4: foreign key between the keys
        wr_reg(kw(4'h5, 2'b01));
        wr_reg(kw(4'h3, 2'b01));
        wr_reg(kw(4'hA, 2'b01));
        settle_idle("R4 foreign key between keys");
        // R5: mode mismatch
        wr_reg(kw(4'h5, 2'b10));
        wr_reg(kw(4'hA, 2'b01));
        settle_idle("R5 mode mismatch");
        chk(reg_rdata[2:1] == 2'b01, "R3 R5 stored mode readback", PB'(reg_rdata[2:1]), 1);
        // R7 extra row; buffer survived the aborts
        go(2'b01);

        // R12: re-arm with a new mode
        ld(9'h1F0, 64, 8'hC3);
        wr_reg(kw(4'h5, 2'b10));
        wr_reg(kw(4'h5, 2'b01));
        launch_go(2'b01);

        // R7: configuration-bit mode, ignored bits 3 and 0 set
        ld(9'h000, 3, 8'h81);
        wr_reg(8'h5D);
        launch_go(2'b10);

        // R11: writes and loads while busy
        ld(9'h020, 4, 8'h99);
        wr_reg(kw(4'h5, 2'b00));
        q.push_back('{mode: 2'b00, page: m_page, mask: m_mask, data: m_data});
        m_mask = '0;
        wr_reg(kw(4'hA, 2'b00));
        @(negedge clk);
        chk(busy == 1'b1, "R6 busy set before ignored writes", PB'(busy), 1);
        ld_wr = 1'b1; ld_addr = {9'h033, 7'd9}; ld_data = 8'hEE;
        @(negedge clk);
        ld_wr = 1'b0;
        reg_wr = 1'b1; reg_wdata = kw(4'h0, 2'b11);
        @(negedge clk);
        reg_wr = 1'b0;
        chk(reg_rdata == 8'h01, "R11 readback unchanged while busy", PB'(reg_rdata), 1);
        wait_idle();
        chk(reg_rdata[2:1] == 2'b00, "R11 mode unchanged after busy", PB'(reg_rdata[2:1]), 0);
        ld(9'h021, 2, 8'h42);
        go(2'b00);

        // R8: clear mode drops loaded bytes without a request
        ld(9'h005, 10, 8'h10);
        ld(9'h005, 11, 8'h20);
        go(2'b11);
        chk(reg_rdata == 8'h06, "R8 readback after clear", PB'(reg_rdata), 6);
        ld(9'h007, 1, 8'h77);
        go(2'b00);

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R7 every expected request issued", PB'(q.size()), 0);
        summary();
    end

endmodule